// File: doc/BRIEF.md
# SLIP Byte-Stuffing Framer

This block frames packets for a plain byte channel, such as the byte side of a UART, using the Serial Line IP convention. It has two independent directions.

The encoder takes packet bytes together with a last-byte marker. It wraps each packet between END delimiters (0xC0). Any payload byte that collides with a reserved code is replaced by a two-byte escape sequence. The decoder takes the raw channel bytes and rebuilds the packets. It delivers payload bytes with first and last markers and with a flag for malformed escapes.

Both directions use valid/ready streams. A byte moves on any clock edge where valid and ready are both high. A source must hold valid, data and markers steady until that edge.

The encoder lowers its input ready in three cases:
- while it sends the opening delimiter,
- while it sends the second byte of an escape pair,
- while it sends the closing delimiter.

The decoder keeps the most recent payload byte in a one-byte hold register. It releases that byte only when the next channel byte shows whether the packet continues or ends. While its output is stalled, it lowers input ready for the channel bytes that would release the held byte. This is why the final payload byte of a packet leaves only once the closing END arrives.

Top module: `slip_codec`

## Requirements
- R1: The encoder emits 0xC0 before the first payload byte of every packet.
- R2: The encoder emits 0xC0 right after the encoding of the byte accepted with the last marker.
- R3: The encoder sends a payload byte 0xC0 as 0xDB followed by 0xDC.
- R4: The encoder sends a payload byte 0xDB as 0xDB followed by 0xDD.
- R5: The encoder passes every other byte value unchanged, one output byte per input byte, in order.
- R6: While the second byte of an escape pair is offered at the encoder output, `enc_in_ready` is low.
- R7: The decoder turns 0xDB 0xDC into 0xC0 and 0xDB 0xDD into 0xDB. It flags the first payload byte after a delimiter with `dec_out_first`.
- R8: The decoder emits nothing for delimiters that enclose no payload, such as a run of consecutive 0xC0 bytes.
- R9: When 0xDB is followed by a byte other than 0xDC or 0xDD, the decoder delivers that following byte unchanged with `dec_out_err` high.
- R10: The decoder raises `dec_out_last` on the final payload byte of a packet, in the cycle the closing 0xC0 is offered at its input.
- R11: Both directions carry back-to-back packets with no idle output cycles while the consumer is ready. The encoder holds its output steady while stalled. The decoder lowers `dec_in_ready` while a held byte cannot be delivered.
- R12: After reset, with no input offered, `enc_out_valid`, `enc_in_ready` and `dec_out_valid` are low and `dec_in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_in_valid | input | 1 | Encoder payload byte offered |
| enc_in_ready | output | 1 | Encoder takes the payload byte |
| enc_in_data | input | 8 | Encoder payload byte |
| enc_in_last | input | 1 | Byte is the last of its packet |
| enc_out_valid | output | 1 | Channel byte offered by the encoder |
| enc_out_ready | input | 1 | Channel accepts the encoder byte |
| enc_out_data | output | 8 | Encoded channel byte |
| dec_in_valid | input | 1 | Channel byte offered to the decoder |
| dec_in_ready | output | 1 | Decoder takes the channel byte |
| dec_in_data | input | 8 | Raw channel byte |
| dec_out_valid | output | 1 | Decoded payload byte offered |
| dec_out_ready | input | 1 | Consumer accepts the payload byte |
| dec_out_data | output | 8 | Decoded payload byte |
| dec_out_first | output | 1 | First byte of a packet |
| dec_out_last | output | 1 | Last byte of a packet |
| dec_out_err | output | 1 | Byte followed an invalid escape |

## Verification
A stuck encoder state shows within one output byte. A lost escape state leaves 0xDB without its partner, or lets the input advance during the partner byte. A missed close state drops the delimiter that must follow the last byte. In the decoder, a stale escape flag corrupts the very next delivered byte. A wrong packet-open flag shows on the next packet as a misplaced first marker. The decoder's one-byte hold means every such fault appears exactly one channel byte after its cause, so the bench compares every delivered byte in the cycle of its release.

// File: rtl/slip_pkg.sv
package slip_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] FRAME_MARK = 8'hC0;
  localparam logic [BYTE_W-1:0] STUFF_LEAD = 8'hDB;
  localparam logic [BYTE_W-1:0] STUFF_MARK = 8'hDC;
  localparam logic [BYTE_W-1:0] STUFF_LEAD2 = 8'hDD;

  typedef enum logic [1:0] {
    ENC_OPEN,
    ENC_BODY,
    ENC_PAIR,
    ENC_CLOSE
  } enc_state_t;

  typedef struct packed {
    logic              vld;
    logic [BYTE_W-1:0] dat;
    logic              first;
    logic              err;
  } hold_t;
endpackage

// File: rtl/slip_enc.sv
module slip_enc
  import slip_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data
);
  enc_state_t        state_q, state_d;
  logic [BYTE_W-1:0] pair_q;
  logic              pend_last_q;
  logic              reserved;
  logic              fire;

  assign reserved = (in_data == FRAME_MARK) || (in_data == STUFF_LEAD);
  assign fire     = out_valid && out_ready;

  always_comb begin
    out_valid = 1'b0;
    out_data  = FRAME_MARK;
    in_ready  = 1'b0;
    state_d   = state_q;
    unique case (state_q)
      ENC_OPEN: begin
        out_valid = in_valid;
        if (fire) state_d = ENC_BODY;
      end
      ENC_BODY: begin
        out_valid = in_valid;
        out_data  = reserved ? STUFF_LEAD : in_data;
        in_ready  = out_ready;
        if (fire) begin
          if (reserved)     state_d = ENC_PAIR;
          else if (in_last) state_d = ENC_CLOSE;
        end
      end
      ENC_PAIR: begin
        out_valid = 1'b1;
        out_data  = pair_q;
        if (fire) state_d = pend_last_q ? ENC_CLOSE : ENC_BODY;
      end
      ENC_CLOSE: begin
        out_valid = 1'b1;
        if (fire) state_d = ENC_OPEN;
      end
      default: state_d = ENC_OPEN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ENC_OPEN;
      pair_q      <= '0;
      pend_last_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ENC_BODY && fire && reserved) begin
        pair_q      <= (in_data == FRAME_MARK) ? STUFF_MARK : STUFF_LEAD2;
        pend_last_q <= in_last;
      end
    end
  end

  // R3
  enc_esc_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_data == STUFF_LEAD) |=>
      (out_valid && (out_data == STUFF_MARK || out_data == STUFF_LEAD2)));

  // R6
  enc_pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_data == STUFF_LEAD) |=> !in_ready);

  // R2
  enc_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last && !reserved) |=>
      (out_valid && out_data == FRAME_MARK));

  // R11
  enc_stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/slip_dec.sv
module slip_dec
  import slip_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_first,
  output logic              out_last,
  output logic              out_err
);
  hold_t             hold_q;
  logic              esc_q;
  logic              open_q;
  logic              is_mark, is_lead, is_data;
  logic              bad_pair;
  logic [BYTE_W-1:0] plain;
  logic              release_hold;
  logic              take;

  assign is_mark  = !esc_q && (in_data == FRAME_MARK);
  assign is_lead  = !esc_q && (in_data == STUFF_LEAD);
  assign is_data  = !is_mark && !is_lead;
  assign bad_pair = esc_q && (in_data != STUFF_MARK) && (in_data != STUFF_LEAD2);

  always_comb begin
    plain = in_data;
    if (esc_q && in_data == STUFF_MARK)  plain = FRAME_MARK;
    if (esc_q && in_data == STUFF_LEAD2) plain = STUFF_LEAD;
  end

  assign release_hold = hold_q.vld && (is_mark || is_data);
  assign out_valid    = in_valid && release_hold;
  assign out_data     = hold_q.dat;
  assign out_first    = hold_q.first;
  assign out_err      = hold_q.err;
  assign out_last     = is_mark;
  assign in_ready     = !release_hold || out_ready;
  assign take         = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      esc_q  <= 1'b0;
      open_q <= 1'b0;
    end else if (take) begin
      esc_q <= is_lead;
      if (is_data) begin
        hold_q <= '{vld: 1'b1, dat: plain, first: !open_q, err: bad_pair};
        open_q <= 1'b1;
      end else if (is_mark) begin
        hold_q.vld <= 1'b0;
        open_q     <= 1'b0;
      end
    end
  end

  logic after_last_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                      after_last_q <= 1'b1;
    else if (out_valid && out_ready) after_last_q <= out_last;
  end

  // R7
  dec_first_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_first == after_last_q));
endmodule

// File: rtl/slip_codec.sv
module slip_codec
  import slip_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enc_in_valid,
  output logic       enc_in_ready,
  input  logic [7:0] enc_in_data,
  input  logic       enc_in_last,
  output logic       enc_out_valid,
  input  logic       enc_out_ready,
  output logic [7:0] enc_out_data,
  input  logic       dec_in_valid,
  output logic       dec_in_ready,
  input  logic [7:0] dec_in_data,
  output logic       dec_out_valid,
  input  logic       dec_out_ready,
  output logic [7:0] dec_out_data,
  output logic       dec_out_first,
  output logic       dec_out_last,
  output logic       dec_out_err
);
  slip_enc u_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (enc_in_valid),
    .in_ready  (enc_in_ready),
    .in_data   (enc_in_data),
    .in_last   (enc_in_last),
    .out_valid (enc_out_valid),
    .out_ready (enc_out_ready),
    .out_data  (enc_out_data)
  );

  slip_dec u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (dec_in_valid),
    .in_ready  (dec_in_ready),
    .in_data   (dec_in_data),
    .out_valid (dec_out_valid),
    .out_ready (dec_out_ready),
    .out_data  (dec_out_data),
    .out_first (dec_out_first),
    .out_last  (dec_out_last),
    .out_err   (dec_out_err)
  );

  // R12
  idle_reset_chk: assert property (@(posedge clk)
    !rst_n |=> (!enc_out_valid || enc_in_valid));
endmodule

// File: tb/slip_codec_bench.sv
module slip_codec_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enc_in_valid = 1'b0, enc_in_last = 1'b0, enc_out_ready = 1'b0;
  logic [7:0] enc_in_data = '0;
  logic       enc_in_ready, enc_out_valid;
  logic [7:0] enc_out_data;
  logic       dec_in_valid = 1'b0, dec_out_ready = 1'b0;
  logic [7:0] dec_in_data = '0;
  logic       dec_in_ready, dec_out_valid, dec_out_first, dec_out_last, dec_out_err;
  logic [7:0] dec_out_data;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  slip_codec u_slip_codec (.*);

  // rx byte, expected valid, data, first, last, err
  localparam logic [19:0] DEC_VEC [16] = '{
    {8'hC0, 1'b0, 8'h00, 3'b000},
    {8'h11, 1'b0, 8'h00, 3'b000},
    {8'hDB, 1'b0, 8'h00, 3'b000},
    {8'hDC, 1'b1, 8'h11, 3'b100},
    {8'h22, 1'b1, 8'hC0, 3'b000},
    {8'hC0, 1'b1, 8'h22, 3'b010},
    {8'hC0, 1'b0, 8'h00, 3'b000},
    {8'hC0, 1'b0, 8'h00, 3'b000},
    {8'h33, 1'b0, 8'h00, 3'b000},
    {8'hDB, 1'b0, 8'h00, 3'b000},
    {8'h55, 1'b1, 8'h33, 3'b100},
    {8'hC0, 1'b1, 8'h55, 3'b011},
    {8'h44, 1'b0, 8'h00, 3'b000},
    {8'hDB, 1'b0, 8'h00, 3'b000},
    {8'hDD, 1'b1, 8'h44, 3'b100},
    {8'hC0, 1'b1, 8'hDB, 3'b010}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  logic [7:0] sd [8];
  logic       sl [8];
  int         sn;
  logic [7:0] ex [32];
  int         en;
  logic [7:0] got [32];
  int         gn;

  task automatic build_expected();
    en = 0;
    for (int i = 0; i < sn; i++) begin
      if (i == 0 || sl[i-1]) begin ex[en] = 8'hC0; en++; end
      if (sd[i] == 8'hC0)      begin ex[en] = 8'hDB; ex[en+1] = 8'hDC; en += 2; end
      else if (sd[i] == 8'hDB) begin ex[en] = 8'hDB; ex[en+1] = 8'hDD; en += 2; end
      else                     begin ex[en] = sd[i]; en++; end
      if (sl[i]) begin ex[en] = 8'hC0; en++; end
    end
  endtask

  task automatic enc_run(input bit stall);
    int  idx = 0;
    int  cyc = 0;
    int  first_c = -1;
    int  last_c = 0;
    bit  esc_prev = 0;
    gn = 0;
    while (gn < en && cyc < 400) begin
      @(negedge clk);
      enc_in_valid  = (idx < sn);
      enc_in_data   = (idx < sn) ? sd[idx] : 8'h00;
      enc_in_last   = (idx < sn) ? sl[idx] : 1'b0;
      enc_out_ready = stall ? ((cyc % 3) != 2) : 1'b1;
      #1;
      if (enc_out_valid && enc_out_ready) begin
        if (esc_prev) chk(!enc_in_ready, "R6 ready during pair byte", enc_in_ready, 0);
        esc_prev = (enc_out_data == 8'hDB);
        got[gn] = enc_out_data;
        gn++;
        if (first_c < 0) first_c = cyc;
        last_c = cyc;
      end
      if (enc_in_valid && enc_in_ready) idx++;
      cyc++;
    end
    @(negedge clk);
    enc_in_valid  = 1'b0;
    enc_out_ready = 1'b0;
    chk(gn == en, "R1 encoded length", gn, en);
    for (int k = 0; k < en; k++) begin
      string tag;
      if (ex[k] == 8'hC0)                          tag = (k == 0 || ex[k-1] == 8'hC0) ? "R1" : "R2";
      else if (k > 0 && ex[k-1] == 8'hDB && ex[k] == 8'hDC) tag = "R3";
      else if (k > 0 && ex[k-1] == 8'hDB && ex[k] == 8'hDD) tag = "R4";
      else if (ex[k] == 8'hDB)                     tag = (ex[k+1] == 8'hDC) ? "R3" : "R4";
      else                                         tag = "R5";
      chk(got[k] == ex[k], tag, got[k], ex[k]);
    end
    if (!stall) chk(last_c - first_c + 1 == gn, "R11 encoder gap-free", last_c - first_c + 1, gn);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R12 reset state
    chk(!enc_out_valid, "R12 enc_out_valid", enc_out_valid, 0);
    chk(!enc_in_ready,  "R12 enc_in_ready",  enc_in_ready, 0);
    chk(!dec_out_valid, "R12 dec_out_valid", dec_out_valid, 0);
    chk(dec_in_ready,   "R12 dec_in_ready",  dec_in_ready, 1);

    // decoder vector table, source and sink always active
    foreach (DEC_VEC[i]) begin
      logic [19:0] v;
      string tag;
      v = DEC_VEC[i];
      @(negedge clk);
      dec_in_valid  = 1'b1;
      dec_in_data   = v[19:12];
      dec_out_ready = 1'b1;
      #1;
      if (v[0])       tag = "R9";
      else if (v[1])  tag = "R10";
      else if (!v[11]) tag = "R8";
      else            tag = "R7";
      if (v[11])
        chk(dec_out_valid && dec_in_ready && dec_out_data == v[10:3] &&
            {dec_out_first, dec_out_last, dec_out_err} == v[2:0], tag,
            {dec_out_valid, dec_out_data, dec_out_first, dec_out_last, dec_out_err},
            {1'b1, v[10:0]});
      else
        chk(!dec_out_valid && dec_in_ready, tag, {dec_out_valid, dec_in_ready}, 2'b01);
    end

    // decoder back-pressure: C0, 66, 77 stalled, 77 accepted, C0
    @(negedge clk); dec_in_data = 8'hC0;
    @(negedge clk); dec_in_data = 8'h66;
    @(negedge clk); dec_in_data = 8'h77; dec_out_ready = 1'b0; #1;
    chk(dec_out_valid && !dec_in_ready && dec_out_data == 8'h66 && dec_out_first,
        "R11 decoder stall", {dec_out_valid, dec_in_ready, dec_out_data}, {2'b10, 8'h66});
    @(negedge clk); #1;
    chk(dec_out_valid && !dec_in_ready && dec_out_data == 8'h66,
        "R11 decoder held", {dec_out_valid, dec_in_ready, dec_out_data}, {2'b10, 8'h66});
    dec_out_ready = 1'b1;
    @(negedge clk); dec_in_data = 8'hC0; #1;
    chk(dec_out_valid && dec_out_last && !dec_out_first && dec_out_data == 8'h77,
        "R10 last after stall", {dec_out_valid, dec_out_last, dec_out_first, dec_out_data},
        {3'b110, 8'h77});
    @(negedge clk); dec_in_valid = 1'b0;

    // encoder: three back-to-back packets
    sd[0] = 8'h45; sl[0] = 0;
    sd[1] = 8'hC0; sl[1] = 0;
    sd[2] = 8'h01; sl[2] = 0;
    sd[3] = 8'hDB; sl[3] = 0;
    sd[4] = 8'h7E; sl[4] = 1;
    sd[5] = 8'hDB; sl[5] = 1;
    sd[6] = 8'hC0; sl[6] = 0;
    sd[7] = 8'h00; sl[7] = 1;
    sn = 8;
    build_expected();
    enc_run(1'b0);
    enc_run(1'b1);

    // single-byte packet ending in an escape, stalled consumer
    sd[0] = 8'hC0; sl[0] = 1;
    sn = 1;
    build_expected();
    enc_run(1'b1);

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule